// File: doc/BRIEF.md
# Prefixed Bit-Scan Encoding Page Scanner

This block inspects a memory page one byte per cycle. It looks for any place where a legacy-prefixed bit-scan opcode could begin. Such an opcode is a run of prefix bytes that contains 0xF3, then the escape byte 0x0F, then 0xBD (leading-zero count) or 0xBC (trailing-zero count). These byte patterns decode differently on different processor generations. A page that holds one therefore cannot be handed to hardware for direct execution under a simulator, and has to be interpreted or translated instead.

Software pulses `start`, then streams the page with `byte_vld`, marking the final byte with `byte_last`. Each match raises `hit` for one cycle and gives on `hit_off` the page offset of the earliest byte of the reported encoding. The cycle after the last byte, `done` pulses, and `clean` tells whether the page is free of matches. The scan is conservative: every byte offset is considered, and the block does not try to find instruction boundaries.

Top module: `byte_pattern_scan`

## Requirements
- R1: After reset, `hit` and `done` are low and `clean` is high.
- R2: The sequence F3 0F BD raises `hit` for one cycle, in the cycle after the BD byte is accepted, with `hit_off` equal to the offset of the F3 byte.
- R3: The sequence F3 0F BC is reported in the same way as R2.
- R4: A prefix run may mix and repeat any of 26, 2E, 36, 3E, 64, 65, 66, 67, F0, F2 and F3. A run of at most MAX_LEN-2 prefixes that contains F3, followed by 0F and then BD or BC, is reported with `hit_off` equal to the offset of the first prefix of the run.
- R5: A prefix run without F3, or no prefix run at all, before 0F BD or 0F BC produces no `hit`.
- R6: An encoding is never longer than MAX_LEN bytes (default 15). When the prefix run is longer than MAX_LEN-2 bytes, a hit is reported only if an F3 lies within the last MAX_LEN-2 prefix bytes. `hit_off` is then the offset of the BD or BC byte minus (MAX_LEN-1).
- R7: Any accepted byte that is neither a prefix nor 0F ends the current prefix run. So does a second 0F, and so does any byte other than BD or BC after 0F. No hit spans such a break.
- R8: `done` pulses for one cycle, in the cycle after a byte with `byte_last` high is accepted. `clean` is then low if any hit occurred since the last `start`, counting a hit on that last byte, and high otherwise.
- R9: `start` clears the byte offset counter, the prefix run state and the match history, so `clean` is high the next cycle. A byte presented in the same cycle as `start` is discarded.
- R10: Cycles with `byte_vld` low do not advance the offset and do not disturb the run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new page scan |
| byte_vld | input | 1 | `byte_data` holds a page byte this cycle |
| byte_data | input | 8 | Page byte |
| byte_last | input | 1 | This byte is the last of the page |
| hit | output | 1 | One-cycle match pulse |
| hit_off | output | ADDR_W | Offset of the first byte of the match |
| done | output | 1 | One-cycle end-of-page pulse |
| clean | output | 1 | No match since `start` |

## Verification
The bench builds the block with its defaults, ADDR_W = 12 and MAX_LEN = 15. The 15-byte limit lets directed runs of 13, 14 and 15 prefixes sit right on the window boundary, so the saturating run counters are tested at their limit. A 12-bit offset covers a full 4 KiB page, so one scenario streams 4096 bytes and places a match at offset 4093, which exercises the top of the offset counter.

// File: rtl/byte_pattern_scan.sv
module byte_pattern_scan #(
  parameter int ADDR_W  = 12,
  parameter int MAX_LEN = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic              byte_last,
  output logic              hit,
  output logic [ADDR_W-1:0] hit_off,
  output logic              done,
  output logic              clean
);
  localparam int MAX_PFX = MAX_LEN - 2;
  localparam int CW      = $clog2(MAX_PFX + 1);
  localparam logic [CW-1:0] PFX_SAT = CW'(MAX_PFX);

  logic [ADDR_W-1:0] pos;
  logic [CW-1:0]     run_len;
  logic [CW-1:0]     f3_dist;
  logic              esc;
  logic              dirty;

  wire take    = byte_vld & ~start;
  wire is_f3   = byte_data == 8'hF3;
  wire is_esc  = byte_data == 8'h0F;
  wire is_scan = (byte_data == 8'hBD) | (byte_data == 8'hBC);
  wire is_pfx  = (byte_data == 8'h26) | (byte_data == 8'h2E) |
                 (byte_data == 8'h36) | (byte_data == 8'h3E) |
                 (byte_data == 8'h64) | (byte_data == 8'h65) |
                 (byte_data == 8'h66) | (byte_data == 8'h67) |
                 (byte_data == 8'hF0) | (byte_data == 8'hF2) | is_f3;

  wire found = take & esc & is_scan & (run_len != '0) & (f3_dist < run_len);

  wire [ADDR_W-1:0] first_off = pos - ADDR_W'(1) - ADDR_W'(run_len);
  wire [CW-1:0]     len_inc   = (run_len == PFX_SAT) ? run_len : run_len + CW'(1);
  wire [CW-1:0]     f3_inc    = (f3_dist == PFX_SAT) ? f3_dist : f3_dist + CW'(1);

  assign clean = ~dirty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos     <= '0;
      run_len <= '0;
      f3_dist <= PFX_SAT;
      esc     <= 1'b0;
      dirty   <= 1'b0;
      hit     <= 1'b0;
      hit_off <= '0;
      done    <= 1'b0;
    end else begin
      hit  <= found;
      done <= take & byte_last;
      if (found) hit_off <= first_off;
      if (start) begin
        pos     <= '0;
        run_len <= '0;
        f3_dist <= PFX_SAT;
        esc     <= 1'b0;
        dirty   <= 1'b0;
      end else begin
        if (found) dirty <= 1'b1;
        if (byte_vld) begin
          pos <= pos + ADDR_W'(1);
          if (is_pfx) begin
            if (esc) begin
              run_len <= CW'(1);
              f3_dist <= is_f3 ? '0 : PFX_SAT;
              esc     <= 1'b0;
            end else begin
              run_len <= len_inc;
              f3_dist <= is_f3 ? '0 : f3_inc;
            end
          end else if (is_esc) begin
            if (esc) begin
              run_len <= '0;
              f3_dist <= PFX_SAT;
            end
            esc <= 1'b1;
          end else begin
            run_len <= '0;
            f3_dist <= PFX_SAT;
            esc     <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/scan_chk.sv
module scan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       byte_vld,
  input logic [7:0] byte_data,
  input logic       byte_last,
  input logic       hit,
  input logic       done,
  input logic       clean
);
  p_done_follows_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_last && !start) |=> done);

  p_done_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(byte_vld && byte_last && !start));

  p_hit_marks_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !clean);

  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (clean && !hit && !done));

  p_hit_on_opcode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(byte_vld && (byte_data == 8'hBD || byte_data == 8'hBC)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> (!hit && !done));
endmodule

bind byte_pattern_scan scan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .byte_vld(byte_vld),
  .byte_data(byte_data), .byte_last(byte_last), .hit(hit),
  .done(done), .clean(clean)
);

// File: tb/sim_byte_pattern_scan.sv
module sim_byte_pattern_scan;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic byte_vld = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic byte_last = 1'b0;
  logic hit;
  logic [11:0] hit_off;
  logic done;
  logic clean;

  int checks = 0;
  int failures = 0;
  int hits = 0;
  int dones = 0;
  int last_off = -1;
  int done_clean = -1;

  always #2 clk = ~clk;

  byte_pattern_scan u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_vld(byte_vld),
    .byte_data(byte_data), .byte_last(byte_last), .hit(hit),
    .hit_off(hit_off), .done(done), .clean(clean)
  );

  always @(negedge clk) begin
    if (hit) begin
      hits++;
      last_off = int'(hit_off);
    end
    if (done) begin
      dones++;
      done_clean = int'(clean);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    hits = 0;
    dones = 0;
    last_off = -1;
    done_clean = -1;
  endtask

  task automatic begin_page();
    clear_log();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic push(input logic [7:0] b, input bit last = 1'b0);
    byte_vld = 1'b1;
    byte_data = b;
    byte_last = last;
    @(negedge clk);
    byte_vld = 1'b0;
    byte_last = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(hit == 1'b0, "R1 hit", int'(hit), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(clean == 1'b1, "R1 clean", int'(clean), 1);
  endtask

  task automatic t_lzcnt();
    begin_page();
    push(8'h90); push(8'hF3); push(8'h0F); push(8'hBD, 1'b1);
    idle(2);
    chk(hits == 1, "R2 hit count", hits, 1);
    chk(last_off == 1, "R2 offset", last_off, 1);
    chk(dones == 1, "R8 done count", dones, 1);
    chk(done_clean == 0, "R8 clean after hit", done_clean, 0);
  endtask

  task automatic t_tzcnt();
    begin_page();
    push(8'hF3); push(8'h0F); push(8'hBC, 1'b1);
    idle(2);
    chk(hits == 1, "R3 hit count", hits, 1);
    chk(last_off == 0, "R3 offset", last_off, 0);
  endtask

  task automatic t_mixed();
    begin_page();
    push(8'h90); push(8'h66); push(8'hF3); push(8'h66); push(8'h2E);
    push(8'hF3); push(8'h67); push(8'h0F); push(8'hBD); push(8'h90, 1'b1);
    idle(2);
    chk(hits == 1, "R4 hit count", hits, 1);
    chk(last_off == 1, "R4 run start offset", last_off, 1);
  endtask

  task automatic t_no_f3();
    begin_page();
    push(8'h66); push(8'h0F); push(8'hBD);
    push(8'h0F); push(8'hBD);
    push(8'hF2); push(8'h0F); push(8'hBC);
    push(8'h90, 1'b1);
    idle(2);
    chk(hits == 0, "R5 no hit", hits, 0);
    chk(done_clean == 1, "R8 clean page", done_clean, 1);
  endtask

  task automatic t_window();
    begin_page();
    push(8'hF3);
    for (int i = 0; i < 13; i++) push(8'h66);
    push(8'h0F); push(8'hBD, 1'b1);
    idle(2);
    chk(hits == 0, "R6 F3 outside window", hits, 0);

    begin_page();
    for (int i = 0; i < 14; i++) push(8'h66);
    push(8'hF3); push(8'h0F); push(8'hBD, 1'b1);
    idle(2);
    chk(hits == 1, "R6 long run hit count", hits, 1);
    chk(last_off == 2, "R6 long run offset", last_off, 2);

    begin_page();
    push(8'hF3);
    for (int i = 0; i < 12; i++) push(8'h3E);
    push(8'h0F); push(8'hBC, 1'b1);
    idle(2);
    chk(hits == 1, "R6 exact 15 bytes hit", hits, 1);
    chk(last_off == 0, "R6 exact 15 bytes offset", last_off, 0);
  endtask

  task automatic t_break();
    begin_page();
    push(8'hF3); push(8'h90); push(8'h0F); push(8'hBD);
    push(8'hF3); push(8'h0F); push(8'h0F); push(8'hBD);
    push(8'hF3); push(8'h0F); push(8'h66); push(8'hBD, 1'b1);
    idle(2);
    chk(hits == 0, "R7 broken runs", hits, 0);
    chk(done_clean == 1, "R7 clean", done_clean, 1);
  endtask

  task automatic t_gap();
    begin_page();
    push(8'hF3); idle(2);
    chk(dones == 0 && hits == 0, "R10 idle quiet", dones + hits, 0);
    push(8'h0F); idle(1);
    push(8'hBD, 1'b1);
    idle(2);
    chk(hits == 1, "R10 gapped hit", hits, 1);
    chk(last_off == 0, "R10 gapped offset", last_off, 0);
    chk(dones == 1, "R10 done once", dones, 1);
  endtask

  task automatic t_restart();
    begin_page();
    push(8'hF3); push(8'h0F); push(8'hBD, 1'b1);
    idle(1);
    begin_page();
    chk(clean == 1'b1, "R9 clean after start", int'(clean), 1);
    push(8'hF3);
    begin_page();
    push(8'h0F); push(8'hBD, 1'b1);
    idle(2);
    chk(hits == 0, "R9 run cleared", hits, 0);
    chk(done_clean == 1, "R9 history cleared", done_clean, 1);
    begin_page();
    push(8'h90); push(8'hF3); push(8'h0F); push(8'hBD, 1'b1);
    idle(2);
    chk(last_off == 1, "R9 offset cleared", last_off, 1);
  endtask

  task automatic t_full_page();
    begin_page();
    for (int i = 0; i < 4093; i++) push(8'h90);
    push(8'hF3); push(8'h0F); push(8'hBD, 1'b1);
    idle(2);
    chk(hits == 1, "R2 page end hit", hits, 1);
    chk(last_off == 4093, "R2 page end offset", last_off, 4093);
    chk(done_clean == 0, "R8 page end dirty", done_clean, 0);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lzcnt();
    t_tzcnt();
    t_mixed();
    t_no_f3();
    t_window();
    t_break();
    t_gap();
    t_restart();
    t_full_page();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule